// File: doc/BRIEF.md
# Cascaded Learn and Next-Free Controller

This block keeps the occupancy and learning state of one device in a chain of devices that together hold one associative table. It holds one occupied flag for each 72-bit entry and finds the next free slot with a priority encoder. It combines its own fullness with the full indication from upstream to produce a full indication for the device below. Software-visible writes pass straight through to the entry array and update the occupied flag from bit 0 of the written word. A learn command copies one or two of sixteen comparand registers into the next free slot or slot pair, and issues one write to the external associated-data SRAM.

A learn is carried out only by the first device in the chain that still has room. That device sees full-in high because every upstream device is full, and it is not full itself. The controller is a three-state machine. In `IDLE` it accepts writes, or it accepts a learn and latches the pointer and comparand data; a write has priority over a learn. The transition `IDLE -> ARM` is taken on an accepted learn. `ARM -> COMMIT` and `COMMIT -> IDLE` are taken unconditionally. A learn therefore occupies exactly two cycles after it is accepted. Commands that arrive in `ARM` or `COMMIT` are dropped.

Top module: `cascade_learn_ctrl`

## Requirements
- R1: After reset every entry is empty, no array or SRAM write is issued, `sram_oe_n` is 0, and the state is `IDLE`.
- R2: In `IDLE`, a write command drives the array port in the same cycle with `wr_addr`/`wr_data`. From the next cycle on, the entry's occupied flag equals `wr_data[0]`.
- R3: The learn target is the lowest-indexed empty entry in 72-bit mode (`width_mode`=00). In 144-bit mode (`width_mode`=01) it is the lowest even index whose entry and the odd entry after it are both empty.
- R4: `full_out` is 1 exactly when `full_in` is 1 and the current mode has no free slot. It follows occupancy and mode changes in the same cycle.
- R5: A learn is accepted only when `full_in` is 1 and this device has a free slot in the current mode. Otherwise it writes nothing and leaves the occupancy unchanged.
- R6: In a 72-bit learn, in the `ARM` cycle the array port writes the target with comparand `learn_sel`, with bit 0 forced to 1. The entry is then occupied.
- R7: In a 144-bit learn, `ARM` writes the even target with comparand `{learn_sel[3:1],0}`. `COMMIT` writes target+1 with comparand `{learn_sel[3:1],1}`. Both words have bit 0 forced to 1, and both entries become occupied.
- R8: In the `COMMIT` cycle exactly one SRAM write is issued, with `sram_addr` = `{DEV_ID, target}`.
- R9: `sram_oe_n` is 1 in the `ARM` and `COMMIT` cycles of a learn and 0 otherwise.
- R10: When a write and a learn arrive in the same `IDLE` cycle, only the write is performed. Write and learn commands presented during `ARM` or `COMMIT` are ignored.
- R11: A comparand write stores `cmp_data` in register `cmp_idx` at any time. A learn uses the register contents as they were in the cycle the learn was accepted.
- R12: A learn with `width_mode[1]`=1 (288-bit table) is ignored.
- R13: A learn while `global_full` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write command |
| wr_addr | input | ADDR_W | Entry index for a write |
| wr_data | input | KEY_W | Word to write; bit 0 is the occupied flag |
| cmp_we | input | 1 | Comparand register write |
| cmp_idx | input | CIDX_W | Comparand register index |
| cmp_data | input | KEY_W | Comparand value |
| learn_req | input | 1 | Learn command |
| learn_sel | input | CIDX_W | Comparand register chosen for the learn |
| width_mode | input | 2 | 00 = 72-bit, 01 = 144-bit, 1x = 288-bit |
| full_in | input | 1 | All upstream devices are full (tie to 1 on the first device) |
| global_full | input | 1 | Full indication of the last device in the chain |
| full_out | output | 1 | This device and all upstream devices are full |
| arr_we | output | 1 | Entry array write strobe |
| arr_addr | output | ADDR_W | Entry array write index |
| arr_data | output | KEY_W | Entry array write data |
| sram_we | output | 1 | External SRAM write strobe |
| sram_addr | output | DEV_W+ADDR_W | External SRAM address |
| sram_oe_n | output | 1 | Active-low SRAM output enable, raised during a learn |

## Verification
The bench makes holes in the occupancy so that the lowest free single entry and the lowest free pair differ. A finder that ignored pair alignment would then send a 144-bit learn to an odd slot or to a half-used pair. It fills the device completely, then frees one odd entry. The device must be non-full in 72-bit mode but still full in 144-bit mode; a fullness test shared between the modes would report the wrong `full_out`. It collides writes with learns and sends commands during the two learn cycles, which exposes a wrong priority order or a controller that re-enters mid-learn. It also rewrites a comparand in the cycle a learn is accepted, so a design that read the comparand late would store the new value.

// File: rtl/cascade_learn_pkg.sv
package cascade_learn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ARM    = 2'b01,
        ST_COMMIT = 2'b10
    } lrn_state_e;
endpackage

// File: rtl/cmp_bank.sv
module cmp_bank #(
    parameter int KEY_W  = 72,
    parameter int CMP_N  = 16,
    localparam int CIDX_W = $clog2(CMP_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CIDX_W-1:0] widx,
    input  logic [KEY_W-1:0]  wdata,
    input  logic [CIDX_W-1:0] ridx_a,
    input  logic [CIDX_W-1:0] ridx_b,
    output logic [KEY_W-1:0]  rdata_a,
    output logic [KEY_W-1:0]  rdata_b
);
    logic [KEY_W-1:0] regs [CMP_N];

    for (genvar g = 0; g < CMP_N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && widx == CIDX_W'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[ridx_a];
    assign rdata_b = regs[ridx_b];
endmodule

// File: rtl/free_finder.sv
module free_finder #(
    parameter int ENTRIES = 32,
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ENTRIES-1:0] occ,
    input  logic              pair_mode,
    output logic [ADDR_W-1:0] ptr,
    output logic              none_free
);
    logic [ENTRIES-1:0] slot_free;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        if ((g % 2 == 0) && (g + 1 < ENTRIES)) begin : g_even
            assign slot_free[g] = pair_mode ? (!occ[g] && !occ[g+1]) : !occ[g];
        end else begin : g_single
            assign slot_free[g] = pair_mode ? 1'b0 : !occ[g];
        end
    end

    always_comb begin
        ptr = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (slot_free[i])
                ptr = ADDR_W'(i);
        end
    end

    assign none_free = ~|slot_free;

    AST_PTR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !none_free |-> (!occ[ptr] && (!pair_mode || !ptr[0]))); // R3
endmodule

// File: rtl/cascade_learn_ctrl.sv
module cascade_learn_ctrl
    import cascade_learn_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int KEY_W   = 72,
    parameter int CMP_N   = 16,
    parameter int DEV_W   = 2,
    parameter int DEV_ID  = 0,
    localparam int ADDR_W = $clog2(ENTRIES),
    localparam int CIDX_W = $clog2(CMP_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [KEY_W-1:0]        wr_data,
    input  logic                    cmp_we,
    input  logic [CIDX_W-1:0]       cmp_idx,
    input  logic [KEY_W-1:0]        cmp_data,
    input  logic                    learn_req,
    input  logic [CIDX_W-1:0]       learn_sel,
    input  logic [1:0]              width_mode,
    input  logic                    full_in,
    input  logic                    global_full,
    output logic                    full_out,
    output logic                    arr_we,
    output logic [ADDR_W-1:0]       arr_addr,
    output logic [KEY_W-1:0]        arr_data,
    output logic                    sram_we,
    output logic [DEV_W+ADDR_W-1:0] sram_addr,
    output logic                    sram_oe_n
);
    lrn_state_e        state_q, state_d;
    logic [ENTRIES-1:0] occ_q;
    logic [ADDR_W-1:0] ptr_q, nfa;
    logic              pair_q, none_free;
    logic [KEY_W-1:0]  key_lo_q, key_hi_q, rd_a, rd_b;
    logic [CIDX_W-1:0] sel_a, sel_b;
    logic              mode_pair, mode_wide, learn_ok;

    assign mode_pair = (width_mode == 2'b01);
    assign mode_wide = width_mode[1];

    assign sel_a = mode_pair ? {learn_sel[CIDX_W-1:1], 1'b0} : learn_sel;
    assign sel_b = {learn_sel[CIDX_W-1:1], 1'b1};

    cmp_bank #(.KEY_W(KEY_W), .CMP_N(CMP_N)) u_cmp (
        .clk(clk), .rst_n(rst_n), .we(cmp_we), .widx(cmp_idx), .wdata(cmp_data),
        .ridx_a(sel_a), .ridx_b(sel_b), .rdata_a(rd_a), .rdata_b(rd_b)
    );

    free_finder #(.ENTRIES(ENTRIES)) u_find (
        .clk(clk), .rst_n(rst_n), .occ(occ_q), .pair_mode(mode_pair),
        .ptr(nfa), .none_free(none_free)
    );

    assign full_out = full_in && none_free;

    assign learn_ok = (state_q == ST_IDLE) && !wr_en && learn_req && full_in
                      && !none_free && !global_full && !mode_wide;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (learn_ok) state_d = ST_ARM;
            ST_ARM:    state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // occupancy and learn context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q    <= '0;
            ptr_q    <= '0;
            pair_q   <= 1'b0;
            key_lo_q <= '0;
            key_hi_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_en) begin
                        occ_q[wr_addr] <= wr_data[0];
                    end else if (learn_ok) begin
                        ptr_q    <= nfa;
                        pair_q   <= mode_pair;
                        key_lo_q <= rd_a;
                        key_hi_q <= rd_b;
                    end
                end
                ST_ARM:    occ_q[ptr_q] <= 1'b1;
                ST_COMMIT: if (pair_q) occ_q[{ptr_q[ADDR_W-1:1], 1'b1}] <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        arr_we    = 1'b0;
        arr_addr  = '0;
        arr_data  = '0;
        sram_we   = 1'b0;
        sram_addr = '0;
        sram_oe_n = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                arr_we   = wr_en;
                arr_addr = wr_addr;
                arr_data = wr_data;
            end
            ST_ARM: begin
                arr_we    = 1'b1;
                arr_addr  = ptr_q;
                arr_data  = {key_lo_q[KEY_W-1:1], 1'b1};
                sram_oe_n = 1'b1;
            end
            ST_COMMIT: begin
                arr_we    = pair_q;
                arr_addr  = {ptr_q[ADDR_W-1:1], 1'b1};
                arr_data  = {key_hi_q[KEY_W-1:1], 1'b1};
                sram_we   = 1'b1;
                sram_addr = {DEV_W'(DEV_ID), ptr_q};
                sram_oe_n = 1'b1;
            end
            default: ;
        endcase
    end

    AST_SRAM_AFTER_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> ($past(arr_we) && $past(sram_oe_n))); // R8
    AST_OE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |=> (sram_oe_n && sram_we)); // R9
    AST_FULL_NEEDS_UPSTREAM: assert property (@(posedge clk) disable iff (!rst_n)
        full_out |-> full_in); // R4
    AST_BLOCKED_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && learn_req && !wr_en && (!full_in || global_full || mode_wide))
        |=> !sram_oe_n); // R5
    AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && pair_q) |-> !arr_addr[0]); // R7
    AST_LEARN_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> occ_q[$past(arr_addr)]); // R6
endmodule

// File: tb/test_cascade_learn_ctrl.sv
module test_cascade_learn_ctrl;
    localparam int ENTRIES = 32;
    localparam int KEY_W   = 72;
    localparam int CMP_N   = 16;
    localparam int DEV_W   = 2;
    localparam int DEV_ID  = 2;
    localparam int AW      = $clog2(ENTRIES);
    localparam int CW      = $clog2(CMP_N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, cmp_we = 1'b0, learn_req = 1'b0;
    logic full_in = 1'b1, global_full = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [KEY_W-1:0] wr_data = '0, cmp_data = '0;
    logic [CW-1:0] cmp_idx = '0, learn_sel = '0;
    logic [1:0] width_mode = 2'b00;
    logic full_out, arr_we, sram_we, sram_oe_n;
    logic [AW-1:0] arr_addr;
    logic [KEY_W-1:0] arr_data;
    logic [DEV_W+AW-1:0] sram_addr;

    always #4 clk = ~clk;

    cascade_learn_ctrl #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .CMP_N(CMP_N),
                         .DEV_W(DEV_W), .DEV_ID(DEV_ID)) i_cascade_learn_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmp_we(cmp_we), .cmp_idx(cmp_idx), .cmp_data(cmp_data), .learn_req(learn_req),
        .learn_sel(learn_sel), .width_mode(width_mode), .full_in(full_in),
        .global_full(global_full), .full_out(full_out), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data), .sram_we(sram_we),
        .sram_addr(sram_addr), .sram_oe_n(sram_oe_n)
    );

    // reference model state
    bit m_occ [ENTRIES];
    logic [KEY_W-1:0] m_cmp [CMP_N];
    int m_phase;
    int m_ptr;
    bit m_pair;
    logic [KEY_W-1:0] m_lo, m_hi;
    int checks = 0, errors = 0;
    bit done = 1'b0;
    string scen = "R1 reset";

    function automatic int m_free(bit pair);
        for (int i = 0; i < ENTRIES; i++) begin
            if (pair) begin
                if (i % 2 == 0 && i + 1 < ENTRIES && !m_occ[i] && !m_occ[i+1]) return i;
            end else if (!m_occ[i]) return i;
        end
        return -1;
    endfunction

    task automatic chk(string tag, logic [KEY_W-1:0] act, logic [KEY_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s]: actual %h expected %h", tag, scen, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic e_we, e_swe, e_oe, e_full;
            logic [AW-1:0] e_addr;
            logic [KEY_W-1:0] e_data;
            logic [DEV_W+AW-1:0] e_saddr;
            string atag;
            e_we = 0; e_addr = '0; e_data = '0; e_swe = 0; e_saddr = '0; e_oe = 0;
            atag = "R2 array";
            if (m_phase == 0) begin
                e_we = wr_en; e_addr = wr_addr; e_data = wr_data;
            end else if (m_phase == 1) begin
                e_we = 1; e_addr = AW'(m_ptr); e_data = {m_lo[KEY_W-1:1], 1'b1}; e_oe = 1;
                atag = m_pair ? "R7 array" : "R6 array";
            end else begin
                e_we = m_pair; e_addr = AW'(m_ptr + 1); e_data = {m_hi[KEY_W-1:1], 1'b1};
                e_swe = 1; e_saddr = {DEV_W'(DEV_ID), AW'(m_ptr)}; e_oe = 1;
                atag = "R7 array";
            end
            e_full = full_in && (m_free(width_mode == 2'b01) < 0);
            chk({atag, " we"}, KEY_W'(arr_we), KEY_W'(e_we));
            if (e_we) begin
                chk({atag, " addr"}, KEY_W'(arr_addr), KEY_W'(e_addr));
                chk({atag, " data"}, arr_data, e_data);
            end
            chk("R8 sram_we", KEY_W'(sram_we), KEY_W'(e_swe));
            if (e_swe) chk("R8 sram_addr", KEY_W'(sram_addr), KEY_W'(e_saddr));
            chk("R9 sram_oe_n", KEY_W'(sram_oe_n), KEY_W'(e_oe));
            chk("R4 full_out", KEY_W'(full_out), KEY_W'(e_full));
        end
    end

    // model update at the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) m_occ[i] = 0;
            for (int i = 0; i < CMP_N; i++) m_cmp[i] = '0;
            m_phase = 0; m_ptr = 0; m_pair = 0; m_lo = '0; m_hi = '0;
        end else begin
            if (m_phase == 0) begin
                bit p;
                p = (width_mode == 2'b01);
                if (wr_en) m_occ[wr_addr] = wr_data[0];
                else if (learn_req && full_in && !global_full && !width_mode[1]
                         && m_free(p) >= 0) begin
                    m_ptr = m_free(p); m_pair = p;
                    m_lo = p ? m_cmp[int'(learn_sel) & ~1] : m_cmp[learn_sel];
                    m_hi = m_cmp[int'(learn_sel) | 1];
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                m_occ[m_ptr] = 1; m_phase = 2;
            end else begin
                if (m_pair) m_occ[m_ptr+1] = 1;
                m_phase = 0;
            end
            if (cmp_we) m_cmp[cmp_idx] = cmp_data;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_write(int a, logic [KEY_W-1:0] d);
        wr_en = 1; wr_addr = AW'(a); wr_data = d; tick(); wr_en = 0;
    endtask

    task automatic do_learn(int s);
        learn_req = 1; learn_sel = CW'(s); tick(); learn_req = 0; tick(2);
    endtask

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 full_out", KEY_W'(full_out), '0);
        chk("R1 arr_we", KEY_W'(arr_we), '0);
        chk("R1 sram_we", KEY_W'(sram_we), '0);
        chk("R1 sram_oe_n", KEY_W'(sram_oe_n), '0);
        rst_n = 1; tick();

        scen = "R11 comparand load";
        for (int i = 0; i < CMP_N; i++) begin
            cmp_we = 1; cmp_idx = CW'(i);
            cmp_data = {8'(i + 8'h40), 32'hC0DE_0000 + 32'(i * 3), 32'(i * 32'h0101_0101)};
            tick();
        end
        cmp_we = 0;

        scen = "R2 writes";
        do_write(0, 72'h1);
        do_write(3, 72'hABC1);
        do_write(2, 72'h5);
        do_write(2, 72'h4);
        tick();

        scen = "R3 R7 pair learn skips holes";
        width_mode = 2'b01; do_learn(7);
        scen = "R3 R6 single learn lowest hole";
        width_mode = 2'b00; do_learn(4);

        scen = "R10 write beats learn";
        wr_en = 1; wr_addr = 5'd9; wr_data = 72'h1; learn_req = 1; learn_sel = 4'd2;
        tick(); wr_en = 0; learn_req = 0; tick();
        scen = "R10 commands during learn";
        learn_req = 1; learn_sel = 4'd3; tick(); learn_sel = 4'd8;
        wr_en = 1; wr_addr = 5'd20; wr_data = 72'h1; tick(2);
        wr_en = 0; learn_req = 0; tick();

        scen = "R11 comparand rewritten at accept";
        learn_req = 1; learn_sel = 4'd5; cmp_we = 1; cmp_idx = 4'd5; cmp_data = 72'hFF_FFFF_0000_1234_5678;
        tick(); learn_req = 0; cmp_we = 0; tick(2);
        do_learn(5);

        scen = "R5 upstream not full";
        full_in = 0; do_learn(1); full_in = 1;
        scen = "R13 global full";
        global_full = 1; do_learn(1); global_full = 0;
        scen = "R12 wide table";
        width_mode = 2'b10; do_learn(1); width_mode = 2'b11; do_learn(1); width_mode = 2'b00;

        scen = "R4 fill device";
        for (int i = 0; i < ENTRIES + 4; i++) do_learn(i % CMP_N);
        chk("R4 full when filled", KEY_W'(full_out), KEY_W'(1));
        scen = "R5 learn while self full";
        do_learn(6);
        scen = "R4 upstream low";
        full_in = 0; tick();
        chk("R4 full_out follows full_in", KEY_W'(full_out), '0);
        full_in = 1; tick();

        scen = "R4 odd hole";
        do_write(7, 72'h0);
        chk("R4 not full in single mode", KEY_W'(full_out), '0);
        width_mode = 2'b01; tick();
        chk("R4 full in pair mode", KEY_W'(full_out), KEY_W'(1));
        scen = "R5 pair learn with odd hole";
        do_learn(2);
        width_mode = 2'b00;
        scen = "R6 single learn into odd hole";
        do_learn(9);
        tick(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog [%s]: actual hung expected done", scen);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule